// File: doc/BRIEF.md
# Grouped Pseudo-LRU Victim Selector

This block keeps the replacement state of a 4-way set-associative cache and names the way to evict in the set being looked up. The four ways form two pairs: group 0 holds ways 0 and 1, and group 1 holds ways 2 and 3. Each set keeps three recency bits. One bit tracks which pair was used last. One bit per pair tracks which of its two ways was used last. This approximates a full LRU order with three bits per set instead of a full ranking.

The cache presents the set index and the valid bits of that set's four ways. The victim way comes back in the same cycle. A way that holds no data is always preferred over evicting a live one. When the cache completes a hit or a fill, it pulses the access strobe with the way it touched. The state of that set is updated at the next clock edge. Tag storage, data storage and miss handling sit outside this block.

Top module: `hier_plru_victim`

## Requirements
- R1: After reset, every set whose four ways are all valid yields victim way 0.
- R2: If any way of the indexed set is invalid, the victim is the lowest-numbered invalid way. Bit k of the valid vector belongs to way k.
- R3: If all four ways are valid, the victim lies in the group not used most recently. Ways 0–1 form group 0 and ways 2–3 form group 1.
- R4: If all four ways are valid, the victim is the way inside the chosen group that was not used most recently within that group.
- R5: An access to way w marks w's group as most recent and marks w as most recent within its group. The other group's way bit is kept.
- R6: The victim output follows the set index and the valid vector in the same cycle. An access changes the victim only from the next rising clock edge.
- R7: An access updates only the indexed set; all other sets keep their state.
- R8: While the access strobe is low, the access way input has no effect on any set's state.
- R9: The invalid-first choice of R2 holds whatever the recency state of the set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_idx_i | input | SET_W | Set being looked up and updated |
| acc_valid_i | input | 1 | Hit or fill strobe for the indexed set |
| acc_way_i | input | 2 | Way touched by the hit or fill |
| way_valid_i | input | 4 | Valid bits of the four ways of the indexed set |
| victim_o | output | 2 | Way to replace in the indexed set |

## Verification
Directed access sequences to a single set walk the recency bits through their combinations. After each access, a fully valid lookup shows whether the group choice (R3) and the in-group choice (R4) each follow the last touch, and whether the untouched group's bit survives (R5). Valid vectors with one or more holes are applied against several recency states to separate the invalid-first priority from the recency logic (R2, R9). Strobe-low cycles carry garbage ways, and accesses go to neighbouring sets, to expose leaks between sets or from idle inputs (R7, R8). A long constrained-random run over a small number of sets then mixes all of these.

// File: rtl/hplru_pkg.sv
package hplru_pkg;
  localparam int WAYS     = 4;
  localparam int GROUPS   = 2;
  localparam int WAY_W    = $clog2(WAYS);

  typedef logic [WAY_W-1:0] way_t;

  // Bits point at the colder side; all-zero state selects way 0.
  typedef struct packed {
    logic              cold_grp;
    logic [GROUPS-1:0] cold_way;
  } rec_t;

  localparam int REC_W = $bits(rec_t);
endpackage

// File: rtl/hplru_state_array.sv
module hplru_state_array
  import hplru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  rec_t             wr_rec_i,
  output rec_t             rd_rec_o
);
  rec_t rec_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rec_q[s] <= '0;
      end else if (wr_en_i && idx_i == SET_W'(s)) begin
        rec_q[s] <= wr_rec_i;
      end
    end
  end

  always_comb begin
    rd_rec_o = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (idx_i == SET_W'(s)) rd_rec_o = rec_q[s];
    end
  end
endmodule

// File: rtl/hplru_victim_pick.sv
module hplru_victim_pick
  import hplru_pkg::*;
(
  input  rec_t            rec_i,
  input  logic [WAYS-1:0] valid_i,
  output way_t            victim_o
);
  logic [WAYS-1:0] hole;
  way_t            first_hole;
  way_t            rec_pick;

  assign hole = ~valid_i;

  // Scan high to low so the lowest hole wins.
  always_comb begin
    first_hole = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hole[w]) first_hole = way_t'(w);
    end
  end

  always_comb begin
    rec_pick = {rec_i.cold_grp, rec_i.cold_way[rec_i.cold_grp]};
  end

  assign victim_o = (|hole) ? first_hole : rec_pick;
endmodule

// File: rtl/hplru_update.sv
module hplru_update
  import hplru_pkg::*;
(
  input  rec_t rec_i,
  input  way_t way_i,
  output rec_t rec_o
);
  logic grp;
  logic pos;

  assign grp = way_i[WAY_W-1];
  assign pos = way_i[0];

  always_comb begin
    rec_o               = rec_i;
    rec_o.cold_grp      = ~grp;
    rec_o.cold_way[grp] = ~pos;
  end
endmodule

// File: rtl/hier_plru_victim.sv
module hier_plru_victim
  import hplru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_idx_i,
  input  logic             acc_valid_i,
  input  logic [1:0]       acc_way_i,
  input  logic [3:0]       way_valid_i,
  output logic [1:0]       victim_o
);
  rec_t cur_rec;
  rec_t nxt_rec;

  hplru_state_array #(
    .NUM_SETS(NUM_SETS),
    .SET_W   (SET_W)
  ) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (set_idx_i),
    .wr_en_i (acc_valid_i),
    .wr_rec_i(nxt_rec),
    .rd_rec_o(cur_rec)
  );

  hplru_update u_upd (
    .rec_i(cur_rec),
    .way_i(acc_way_i),
    .rec_o(nxt_rec)
  );

  hplru_victim_pick u_pick (
    .rec_i   (cur_rec),
    .valid_i (way_valid_i),
    .victim_o(victim_o)
  );
endmodule

// File: rtl/hier_plru_victim_chk.sv
module hier_plru_victim_chk #(
  parameter int SET_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SET_W-1:0] set_idx_i,
  input logic             acc_valid_i,
  input logic [1:0]       acc_way_i,
  input logic [3:0]       way_valid_i,
  input logic [1:0]       victim_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  invalid_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&way_valid_i) |-> !way_valid_i[victim_o]);

  // R2
  lowest_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !way_valid_i[0] |-> victim_o == 2'd0);

  // R3
  cold_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && &way_valid_i && $past(acc_valid_i) && set_idx_i == $past(set_idx_i))
      |-> victim_o[1] != $past(acc_way_i[1]));

  // R5
  not_last_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && &way_valid_i && $past(acc_valid_i) && set_idx_i == $past(set_idx_i))
      |-> victim_o != $past(acc_way_i));

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(acc_valid_i) && &way_valid_i && &$past(way_valid_i)
      && set_idx_i == $past(set_idx_i)) |-> $stable(victim_o));
endmodule

bind hier_plru_victim hier_plru_victim_chk #(.SET_W(SET_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .set_idx_i  (set_idx_i),
  .acc_valid_i(acc_valid_i),
  .acc_way_i  (acc_way_i),
  .way_valid_i(way_valid_i),
  .victim_o   (victim_o)
);

// File: tb/hier_plru_victim_test.sv
module hier_plru_victim_test;
  localparam int NS    = 8;
  localparam int SW    = $clog2(NS);
  localparam int LIMIT = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] set_idx = '0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_way = '0;
  logic [3:0]    way_valid = 4'hF;
  logic [1:0]    victim;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // model: [2]=cold group, [1]=cold way in group 1, [0]=cold way in group 0
  logic [2:0] mdl [NS];

  always #4 clk = ~clk;

  hier_plru_victim #(.NUM_SETS(NS)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .set_idx_i  (set_idx),
    .acc_valid_i(acc_valid),
    .acc_way_i  (acc_way),
    .way_valid_i(way_valid),
    .victim_o   (victim)
  );

  function automatic logic [1:0] exp_victim(logic [2:0] r, logic [3:0] v);
    for (int w = 0; w < 4; w++) if (!v[w]) return 2'(w);
    return {r[2], r[r[2]]};
  endfunction

  function automatic logic [2:0] exp_touch(logic [2:0] r, logic [1:0] w);
    logic [2:0] n = r;
    n[2]    = ~w[1];
    n[w[1]] = ~w[0];
    return n;
  endfunction

  // Drive at negedge, check before the next posedge, then let the edge update.
  task automatic step(input logic [SW-1:0] s, input logic av, input logic [1:0] aw,
                      input logic [3:0] vv, input string tag);
    logic [1:0] e;
    @(negedge clk);
    set_idx = s; acc_valid = av; acc_way = aw; way_valid = vv;
    #1;
    e = exp_victim(mdl[s], vv);
    vectors++;
    if (victim !== e) begin
      errors++;
      $display("FAIL %s set=%0d valid=%b got=%0d exp=%0d", tag, s, vv, victim, e);
    end
    @(posedge clk);
    if (av) mdl[s] = exp_touch(mdl[s], aw);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) mdl[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: untouched full sets pick way 0
    for (int s = 0; s < NS; s++) step(SW'(s), 1'b0, 2'd3, 4'hF, "R1");

    // R5/R3/R4: walk set 3
    step(3'd3, 1'b1, 2'd0, 4'hF, "R1");
    step(3'd3, 1'b0, 2'd0, 4'hF, "R3"); // expect way 2
    step(3'd3, 1'b1, 2'd2, 4'hF, "R4");
    step(3'd3, 1'b0, 2'd0, 4'hF, "R4"); // expect way 1
    step(3'd3, 1'b1, 2'd1, 4'hF, "R5");
    step(3'd3, 1'b0, 2'd0, 4'hF, "R5"); // group 1 bit kept: expect way 3
    step(3'd3, 1'b1, 2'd3, 4'hF, "R5");
    step(3'd3, 1'b0, 2'd0, 4'hF, "R3"); // expect way 0

    // R6: victim follows the index in the same cycle, update lands next edge
    step(3'd3, 1'b1, 2'd0, 4'hF, "R6");
    step(3'd3, 1'b0, 2'd0, 4'hF, "R6");

    // R7: neighbour sets untouched
    step(3'd2, 1'b0, 2'd0, 4'hF, "R7");
    step(3'd4, 1'b0, 2'd0, 4'hF, "R7");

    // R8: strobe low with varying way
    for (int k = 0; k < 4; k++) step(3'd5, 1'b0, 2'(k), 4'hF, "R8");

    // R2/R9: holes under differing states
    step(3'd3, 1'b0, 2'd0, 4'b1010, "R2");
    step(3'd3, 1'b0, 2'd0, 4'b0111, "R2");
    step(3'd3, 1'b0, 2'd0, 4'b0000, "R2");
    step(3'd3, 1'b0, 2'd0, 4'b1011, "R9");
    step(3'd1, 1'b0, 2'd0, 4'b1101, "R9");

    // Random mix, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] vv = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      step(SW'($urandom), 1'($urandom), 2'($urandom), vv,
           (vv == 4'hF) ? "R3/R4" : "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    while (cycles < LIMIT) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog after %0d cycles exp=completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule